// File: doc/BRIEF.md
# Misaligned Access Bus Splitter

This block connects a core load/store port to an external bus that can only address whole four-byte groups. The core presents a byte address, a size code, a direction and write data. The block turns that request into one bus transaction, or two if the bytes cross a four-byte boundary. Each transaction carries the group address (the byte address without its two low bits), active-low per-lane byte enables, and write data with every byte on its natural lane.

For reads, the lanes returned by each transaction are collected into a holding word. After the last transaction they are rotated into a right-justified result and reported with a single completion pulse. The core port is blocked for the whole sequence. A combinational flag tells the core whether the presented address is not a multiple of the access size.

Top module: `misalign_split`

## Requirements
- R1: After reset, `bus_valid` and `done` are low and `req_ready` is high.
- R2: An access whose bytes all lie in one four-byte group uses exactly one bus transaction. `bus_be_n[n]` is driven low only for lane n that holds a requested byte.
- R3: An access that crosses a group boundary uses two transactions. The first goes to the lower group address and the second to that address plus one. The second is presented only after the first has been acknowledged.
- R4: On writes, request byte k (`req_wdata[8k+7:8k]`) is driven on lane (addr[1:0]+k) mod 4 of `bus_wdata` in the transaction that covers that byte.
- R5: On reads, result byte k equals the byte returned for byte address addr+k. Bytes at and above the access size read as zero.
- R6: `done` is a one-cycle pulse in the cycle after the final acknowledge, with `rdata` valid in that cycle.
- R7: `req_ready` is low from the cycle after a request is accepted until `done`. A request presented in that window causes no bus activity.
- R8: While `bus_valid` is high and `bus_ack` is low, the bus address, byte enables, write data and direction hold their values into the next cycle.
- R9: `req_misaligned` is high exactly when `req_valid` is high and the address is not a multiple of the access size.
- R10: Size code 0, 1 and 2 select 1, 2 and 4 bytes, and code 3 acts as code 2. `bus_write` equals the request direction in every transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Size code (0:1, 1:2, 2 or 3:4 bytes) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Right-justified write data |
| req_misaligned | output | 1 | Address not a multiple of size |
| done | output | 1 | Completion pulse |
| rdata | output | 32 | Right-justified read result |
| bus_valid | output | 1 | Bus transaction presented |
| bus_ack | input | 1 | Bus accepts/completes the transaction |
| bus_addr | output | 30 | Four-byte group address |
| bus_be_n | output | 4 | Active-low lane enables |
| bus_write | output | 1 | Transaction direction |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The hardest case to reach is a request that arrives while a split is between its two halves. The bench raises a second request right after the first is accepted. It keeps that request up through both acknowledges, with slow acks, and drops it only in the completion cycle. Then it confirms that only the two expected group addresses appeared and that the bus stays idle. The read-merge paths for each offset are reached by sweeping every size at every low-address offset, with a bus model whose byte values depend on the byte address. Acknowledges come both immediately and after several wait cycles.

// File: rtl/split_pkg.sv
package split_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } split_st_e;
endpackage

// File: rtl/split_lane_plan.sv
module split_lane_plan #(
    parameter int NB = 4,
    parameter int OW = 2
) (
    input  logic [OW-1:0] off,
    input  logic [1:0]    size_code,
    output logic [NB-1:0] lo_lanes,
    output logic [NB-1:0] hi_lanes,
    output logic [OW:0]   nbytes,
    output logic          unaligned
);
    logic [2*NB-1:0] span;
    int sz_i;
    int nb_i;
    int off_i;

    always_comb begin
        sz_i  = (int'(size_code) > OW) ? OW : int'(size_code);
        nb_i  = 1 << sz_i;
        off_i = int'(off);
        for (int i = 0; i < 2*NB; i++) begin
            span[i] = (i >= off_i) && (i < off_i + nb_i);
        end
        unaligned = (off_i % nb_i) != 0;
        nbytes    = (OW+1)'(nb_i);
    end

    assign lo_lanes = span[NB-1:0];
    assign hi_lanes = span[2*NB-1:NB];
endmodule

// File: rtl/split_wsteer.sv
module split_wsteer #(
    parameter int NB = 4,
    parameter int OW = 2
) (
    input  logic [OW-1:0]   off,
    input  logic [8*NB-1:0] din,
    output logic [8*NB-1:0] dout
);
    always_comb begin
        dout = '0;
        for (int k = 0; k < NB; k++) begin
            dout[8*((k + int'(off)) % NB) +: 8] = din[8*k +: 8];
        end
    end
endmodule

// File: rtl/split_rmerge.sv
module split_rmerge #(
    parameter int NB = 4,
    parameter int OW = 2
) (
    input  logic [8*NB-1:0] held,
    input  logic [8*NB-1:0] bus_rdata,
    input  logic [NB-1:0]   lanes_now,
    input  logic [OW-1:0]   off,
    input  logic [OW:0]     nbytes,
    output logic [8*NB-1:0] gathered,
    output logic [8*NB-1:0] result
);
    always_comb begin
        for (int j = 0; j < NB; j++) begin
            gathered[8*j +: 8] = lanes_now[j] ? bus_rdata[8*j +: 8] : held[8*j +: 8];
        end
    end

    always_comb begin
        result = '0;
        for (int k = 0; k < NB; k++) begin
            if (k < int'(nbytes)) begin
                result[8*k +: 8] = gathered[8*((k + int'(off)) % NB) +: 8];
            end
        end
    end
endmodule

// File: rtl/misalign_split.sv
module misalign_split
    import split_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_write,
    input  logic [DW-1:0] req_wdata,
    output logic          req_misaligned,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          bus_valid,
    input  logic          bus_ack,
    output logic [AW-1:2] bus_addr,
    output logic [DW/8-1:0] bus_be_n,
    output logic          bus_write,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);
    localparam int NB = DW / 8;
    localparam int OW = $clog2(NB);

    typedef struct packed {
        split_st_e       st;
        logic [AW-1:OW]  grp;
        logic [OW-1:0]   off;
        logic [OW:0]     nb;
        logic            wr;
        logic [DW-1:0]   wlane;
        logic [NB-1:0]   lo;
        logic [NB-1:0]   hi;
        logic [DW-1:0]   gath;
        logic            done;
        logic [DW-1:0]   rdata;
    } split_state_t;

    split_state_t state_d, state_q;

    logic [NB-1:0] plan_lo, plan_hi, cur_lanes;
    logic [OW:0]   plan_nb;
    logic          plan_unal;
    logic [DW-1:0] steered_w, gath_now, merged;

    split_lane_plan #(.NB(NB), .OW(OW)) u_plan (
        .off       (req_addr[OW-1:0]),
        .size_code (req_size),
        .lo_lanes  (plan_lo),
        .hi_lanes  (plan_hi),
        .nbytes    (plan_nb),
        .unaligned (plan_unal)
    );

    split_wsteer #(.NB(NB), .OW(OW)) u_wsteer (
        .off  (req_addr[OW-1:0]),
        .din  (req_wdata),
        .dout (steered_w)
    );

    assign cur_lanes = (state_q.st == ST_SECOND) ? state_q.hi : state_q.lo;

    split_rmerge #(.NB(NB), .OW(OW)) u_rmerge (
        .held      (state_q.gath),
        .bus_rdata (bus_rdata),
        .lanes_now (cur_lanes),
        .off       (state_q.off),
        .nbytes    (state_q.nb),
        .gathered  (gath_now),
        .result    (merged)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        case (state_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d.st    = ST_FIRST;
                    state_d.grp   = req_addr[AW-1:OW];
                    state_d.off   = req_addr[OW-1:0];
                    state_d.nb    = plan_nb;
                    state_d.wr    = req_write;
                    state_d.wlane = steered_w;
                    state_d.lo    = plan_lo;
                    state_d.hi    = plan_hi;
                    state_d.gath  = '0;
                end
            end
            ST_FIRST: begin
                if (bus_ack) begin
                    state_d.gath = gath_now;
                    if (|state_q.hi) begin
                        state_d.st = ST_SECOND;
                    end else begin
                        state_d.st   = ST_IDLE;
                        state_d.done = 1'b1;
                        if (!state_q.wr) state_d.rdata = merged;
                    end
                end
            end
            ST_SECOND: begin
                if (bus_ack) begin
                    state_d.gath = gath_now;
                    state_d.st   = ST_IDLE;
                    state_d.done = 1'b1;
                    if (!state_q.wr) state_d.rdata = merged;
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign req_ready      = (state_q.st == ST_IDLE);
    assign req_misaligned = req_valid & plan_unal;
    assign done           = state_q.done;
    assign rdata          = state_q.rdata;
    assign bus_valid      = (state_q.st != ST_IDLE);
    assign bus_addr       = (state_q.st == ST_SECOND) ? state_q.grp + 1'b1 : state_q.grp;
    assign bus_be_n       = ~cur_lanes;
    assign bus_write      = state_q.wr;
    assign bus_wdata      = state_q.wlane;

    // R8
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_be_n)
                                  && $stable(bus_wdata) && $stable(bus_write));

    // R3
    second_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_FIRST) && bus_ack && (|state_q.hi)
            |=> bus_valid && (bus_addr == $past(bus_addr) + 1'b1));

    // R6
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_ack) && $past(bus_valid));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> bus_valid && !req_ready);

    // R2
    lane_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_be_n != '1);
endmodule

// File: tb/misalign_split_bench.sv
`timescale 1ns/1ps
module misalign_split_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_misaligned, done;
    logic [31:0] req_addr, req_wdata, rdata, bus_wdata, bus_rdata;
    logic [1:0]  req_size;
    logic        bus_valid, bus_ack, bus_write;
    logic [29:0] bus_addr;
    logic [3:0]  bus_be_n;

    int n_chk = 0;
    int n_fail = 0;
    int ack_delay = 0;
    int wcnt = 0;
    int n_tr = 0;
    logic [29:0] lg_addr [4];
    logic [3:0]  lg_be   [4];
    logic [31:0] lg_wd   [4];
    logic        lg_wr   [4];

    always #2.5 clk = ~clk;

    misalign_split u_misalign_split (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .req_misaligned(req_misaligned), .done(done),
        .rdata(rdata), .bus_valid(bus_valid), .bus_ack(bus_ack),
        .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] model(input logic [31:0] ba);
        return ba[7:0] * 8'd7 + ba[15:8] + 8'h3d;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // bus responder
    initial begin
        bus_ack = 1'b0;
        bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
                wcnt = 0;
            end else if (bus_valid && rst_n) begin
                if (wcnt >= ack_delay) begin
                    for (int l = 0; l < 4; l++) bus_rdata[8*l +: 8] = model({bus_addr, 2'(l)});
                    if (n_tr < 4) begin
                        lg_addr[n_tr] = bus_addr;
                        lg_be[n_tr]   = bus_be_n;
                        lg_wd[n_tr]   = bus_wdata;
                        lg_wr[n_tr]   = bus_write;
                    end
                    n_tr++;
                    bus_ack = 1'b1;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R6 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    task automatic do_access(input logic [31:0] addr, input logic [1:0] size,
                             input logic wr, input logic [31:0] wd);
        int nb;
        int first_g, last_g, exp_tr;
        bit busy_hi;
        logic [31:0] rd, exp_rd, exp_wd, mask;
        logic [3:0] exp_be;
        nb = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        n_tr = 0;
        req_addr = addr; req_size = size; req_write = wr; req_wdata = wd;
        req_valid = 1'b1;
        #1;
        chk(req_misaligned == ((addr % nb) != 0), "R9 misaligned flag", req_misaligned, (addr % nb) != 0);
        @(negedge clk);
        req_valid = 1'b0;
        busy_hi = 1'b0;
        while (!done) begin
            if (req_ready) busy_hi = 1'b1;
            @(negedge clk);
        end
        rd = rdata;
        chk(!busy_hi, "R7 ready low while busy", busy_hi, 0);
        @(negedge clk);
        chk(!done, "R6 done single pulse", done, 0);
        first_g = int'(addr >> 2);
        last_g  = int'((addr + nb - 1) >> 2);
        exp_tr  = (last_g != first_g) ? 2 : 1;
        chk(n_tr == exp_tr, "R2/R3 transaction count", n_tr, exp_tr);
        for (int t = 0; t < exp_tr && t < n_tr; t++) begin
            exp_be = 4'hf; exp_wd = '0; mask = '0;
            for (int k = 0; k < nb; k++) begin
                logic [31:0] b;
                b = addr + k;
                if (int'(b >> 2) == first_g + t) begin
                    exp_be[b[1:0]] = 1'b0;
                    exp_wd[8*b[1:0] +: 8] = wd[8*k +: 8];
                    mask[8*b[1:0] +: 8] = 8'hff;
                end
            end
            chk(lg_addr[t] == 30'(first_g + t), "R3 group address order", lg_addr[t], first_g + t);
            chk(lg_be[t] == exp_be, "R2 byte enables", lg_be[t], exp_be);
            chk(lg_wr[t] == wr, "R10 bus direction", lg_wr[t], wr);
            if (wr) chk((lg_wd[t] & mask) == exp_wd, "R4 write lane steering", lg_wd[t] & mask, exp_wd);
        end
        if (!wr) begin
            exp_rd = '0;
            for (int k = 0; k < nb; k++) exp_rd[8*k +: 8] = model(addr + k);
            chk(rd == exp_rd, "R5 read merge", rd, exp_rd);
        end
    endtask

    task automatic test_reset();
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(bus_valid == 1'b0, "R1 bus idle after reset", bus_valid, 0);
        chk(done == 1'b0, "R1 done low after reset", done, 0);
    endtask

    task automatic test_reads_all_offsets();
        for (int sz = 0; sz < 3; sz++)
            for (int o = 0; o < 4; o++)
                do_access(32'h0000_1200 + o, 2'(sz), 1'b0, '0);
    endtask

    task automatic test_writes();
        do_access(32'h0000_0102, 2'd2, 1'b1, 32'hA1B2C3D4);
        do_access(32'h0000_0103, 2'd2, 1'b1, 32'h11223344);
        do_access(32'h0000_0343, 2'd1, 1'b1, 32'h0000BEEF);
        do_access(32'h0000_0340, 2'd2, 1'b1, 32'hCAFEF00D);
        do_access(32'h0000_0341, 2'd0, 1'b1, 32'h0000005A);
    endtask

    task automatic test_size3();
        do_access(32'h0000_0101, 2'd3, 1'b0, '0);   // R10 code 3 as 4 bytes
        do_access(32'h0000_0506, 2'd3, 1'b1, 32'h01020304);
    endtask

    task automatic test_busy_ignore();
        logic [31:0] exp_rd;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        n_tr = 0;
        req_addr = 32'h0000_0203; req_size = 2'd1; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 32'h0000_0400; req_size = 2'd2; req_write = 1'b1; req_wdata = 32'hDEADBEEF;
        while (!done) @(negedge clk);
        req_valid = 1'b0;
        exp_rd = {16'h0, model(32'h204), model(32'h203)};
        chk(rdata == exp_rd, "R5 read during busy test", rdata, exp_rd);
        repeat (3) @(negedge clk);
        chk(n_tr == 2, "R7 busy request ignored count", n_tr, 2);
        chk(lg_addr[0] == 30'h80 && lg_addr[1] == 30'h81, "R7 only split groups seen", {lg_addr[0], lg_addr[1]}, {30'h80, 30'h81});
        chk(lg_wr[0] == 1'b0 && lg_wr[1] == 1'b0, "R7 no write issued", {lg_wr[0], lg_wr[1]}, 0);
        chk(bus_valid == 1'b0, "R7 bus idle after ignore", bus_valid, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0; req_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        ack_delay = 0;
        test_reads_all_offsets();
        test_writes();
        ack_delay = 3;
        test_reads_all_offsets();
        test_writes();
        test_size3();
        test_busy_ignore();
        ack_delay = 0;
        do_access(32'h0000_0101, 2'd2, 1'b0, '0);   // R3 worked split example
        summary();
        $finish;
    end
endmodule